// File: doc/BRIEF.md
# Boot-Time Serial Configuration Sequencer

This block is the write-only side of a two-wire (I2C) bus master that sets up an external video encoder. After reset it plays a fixed list of five register writes to the encoder. It holds a reset output to the downstream display logic active until the fifth write has ended. The bus lines are open-drain. Each one has an output value, which is always 0, and a tristate control. A control of 1 releases the line to its pull-up, and a control of 0 pulls it low.

Once the boot list has finished, the block takes single write commands from the register block, each made of one register address byte and one data byte. A command is offered with `cmd_valid` and taken on a cycle where `cmd_ready` is also high. `cmd_ready` stays low from the boot phase until the in-flight write completes, which is the block's back-pressure. While `cmd_ready` is low, a requester keeps `cmd_valid` and its fields steady. The fields are captured on the accepting cycle, and later changes to them have no effect. `cmd_done` pulses for one cycle when the write ends, and the requester uses it to clear its start bit.

Every write has the same shape: a START, the device address byte with R/W=0, the register byte, the data byte, and a STOP. Each byte is sent MSB first. The master releases the data line on the ninth clock so the slave can acknowledge. If the slave does not acknowledge, the transfer is cut short with a STOP and a sticky error flag is set. The done indication still follows, so the sequence can never hang.

Top module: `vbc_top`

## Requirements
- R1: During and right after reset, both tristate controls are 1 (lines released), both output values are 0, `dn_rst_n` is 0, `cmd_ready` is 0 and `ack_err` is 0.
- R2: After reset the block writes, in this order, register 0x49←0xC0, 0x21←0x09, 0x33←0x08, 0x34←0x16, 0x36←0x60. Each write is addressed to the 7-bit device address `DEV_ADDR` (default 0x76, so the first byte on the wire is 0xEC).
- R3: `dn_rst_n` rises only after the STOP of the fifth boot write, and `cmd_ready` is 1 from then on while no command is in flight.
- R4: Each write is a START, then three bytes (address with R/W=0, register, data) sent MSB first, each followed by a ninth clock with the data line released, then a STOP.
- R5: Within a transfer the data line changes only while the clock line is low. The only changes made while the clock is high are the single START (falling) and the single STOP (rising) of each transfer.
- R6: A command is taken on a clock where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 until that write ends, and then `cmd_done` is high for exactly one cycle.
- R7: The register and data fields are captured on the accepting cycle. Changes to them afterwards, and a `cmd_valid` held while `cmd_ready` is 0, do not alter the write in flight. A held command is taken after the current one completes.
- R8: If the slave leaves the line high on a ninth clock, the transfer stops right after that byte with a STOP, `ack_err` becomes 1 and stays 1 until reset, and done is still reported. In the boot phase the list moves on to the next entry.
- R9: Every clock-high pulse of a data or acknowledge bit lasts 2×`QTR_CYC` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_reg | input | 8 | Encoder register address of the command |
| cmd_data | input | 8 | Data byte of the command |
| cmd_done | output | 1 | One-cycle pulse when a command write has ended |
| ack_err | output | 1 | Sticky flag: some byte was not acknowledged |
| dn_rst_n | output | 1 | Downstream reset, low until the boot list is done |
| scl_o | output | 1 | Clock line output value (always 0) |
| scl_t | output | 1 | Clock line tristate control, 1 = released |
| sda_o | output | 1 | Data line output value (always 0) |
| sda_t | output | 1 | Data line tristate control, 1 = released |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
The hardest case to reach from the ports is a missing acknowledge during the boot list. No command can be issued at that point, so the only route to it is a fresh reset while the bus model is set to refuse a byte. The bench does exactly that: it resets a second time with its slave model set to refuse the data byte of every frame. It then checks that all five boot frames still appear in order, that `ack_err` is set, and that `dn_rst_n` is released. Address-byte and data-byte refusals on software commands are reached through rows of the command table.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BIT, PH_STOP} ph_t;

  typedef enum logic [1:0] {SQ_BOOT_GO, SQ_BOOT_WAIT, SQ_IDLE, SQ_BUSY} sq_t;

  localparam int BOOT_LEN = 5;

  // {register, value} of each boot write; order is the play order
  function automatic logic [15:0] boot_entry(input int idx);
    case (idx)
      0:       return 16'h49C0;
      1:       return 16'h2109;
      2:       return 16'h3308;
      3:       return 16'h3416;
      default: return 16'h3660;
    endcase
  endfunction

endpackage

// File: rtl/vbc_tick.sv
module vbc_tick #(
  parameter int unsigned QTR_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(QTR_CYC - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  generate
    if (QTR_CYC > 1) begin : g_chk
      // R9: quarter ticks never come back to back
      p_tick_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/vbc_i2c_wr.sv
module vbc_i2c_wr
  import vbc_pkg::*;
#(
  parameter int unsigned NBYTES = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                go,
  input  logic [8*NBYTES-1:0] frame,
  input  logic                sda_in,
  output logic                busy,
  output logic                done,
  output logic                nack,
  output logic                scl_hi,
  output logic                sda_hi
);
  localparam int SW  = 8 * NBYTES;
  localparam int BCW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  ph_t            ph;
  logic [1:0]     q;
  logic [3:0]     bitn;
  logic [BCW-1:0] bcnt;
  logic [SW-1:0]  sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      q      <= '0;
      bitn   <= '0;
      bcnt   <= '0;
      sh     <= '0;
      scl_hi <= 1'b1;
      sda_hi <= 1'b1;
      done   <= 1'b0;
      nack   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          sh   <= frame;
          ph   <= PH_START;
          q    <= '0;
          bitn <= '0;
          bcnt <= '0;
          nack <= 1'b0;
        end
        PH_START: if (tick) begin
          q <= q + 1'b1;
          if (q == 2'd0) sda_hi <= 1'b0;
          if (q == 2'd2) scl_hi <= 1'b0;
          if (q == 2'd3) ph <= PH_BIT;
        end
        PH_BIT: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_hi <= (bitn == 4'd8) ? 1'b1 : sh[SW-1];
            2'd1: scl_hi <= 1'b1;
            2'd2: ;
            default: begin
              scl_hi <= 1'b0;
              if (bitn != 4'd8) begin
                sh   <= {sh[SW-2:0], 1'b0};
                bitn <= bitn + 1'b1;
              end else begin
                bitn <= '0;
                if (sda_in) begin
                  nack <= 1'b1;
                  ph   <= PH_STOP;
                end else if (bcnt == BCW'(NBYTES - 1)) begin
                  ph <= PH_STOP;
                end else begin
                  bcnt <= bcnt + 1'b1;
                end
              end
            end
          endcase
        end
        default: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_hi <= 1'b0;
            2'd1: scl_hi <= 1'b1;
            2'd2: sda_hi <= 1'b1;
            default: begin
              done <= 1'b1;
              ph   <= PH_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  assign busy = (ph != PH_IDLE);

  // R5: inside a byte the data line holds while the clock is high
  p_sda_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_BIT && scl_hi && $past(scl_hi)) |-> $stable(sda_hi));
  // R1: an idle engine leaves both lines released
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE) |-> (scl_hi && sda_hi));
  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: a new write is only launched into an idle engine
  p_go_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (ph == PH_IDLE));

endmodule

// File: rtl/vbc_top.sv
module vbc_top
  import vbc_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h76,
  parameter int unsigned QTR_CYC  = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [7:0] cmd_reg,
  input  logic [7:0] cmd_data,
  output logic       cmd_done,
  output logic       ack_err,
  output logic       dn_rst_n,
  output logic       scl_o,
  output logic       scl_t,
  output logic       sda_o,
  output logic       sda_t,
  input  logic       sda_i
);
  localparam int BIW = $clog2(BOOT_LEN);

  sq_t            sq;
  logic [BIW-1:0] bidx;
  logic           tick, go, eng_busy, eng_done, eng_nack, scl_hi, sda_hi;
  logic [23:0]    frame;
  logic [15:0]    entry;

  vbc_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  always_comb begin
    cmd_ready = (sq == SQ_IDLE);
    go        = (sq == SQ_BOOT_GO) || (cmd_valid && cmd_ready);
    entry     = boot_entry(int'(bidx));
    frame     = (sq == SQ_BOOT_GO) ? {DEV_ADDR, 1'b0, entry}
                                   : {DEV_ADDR, 1'b0, cmd_reg, cmd_data};
  end

  vbc_i2c_wr #(.NBYTES(3)) u_eng (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .go    (go),
    .frame (frame),
    .sda_in(sda_i),
    .busy  (eng_busy),
    .done  (eng_done),
    .nack  (eng_nack),
    .scl_hi(scl_hi),
    .sda_hi(sda_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq       <= SQ_BOOT_GO;
      bidx     <= '0;
      dn_rst_n <= 1'b0;
      cmd_done <= 1'b0;
      ack_err  <= 1'b0;
    end else begin
      cmd_done <= (sq == SQ_BUSY) && eng_done;
      if (eng_done && eng_nack) ack_err <= 1'b1;
      case (sq)
        SQ_BOOT_GO:   sq <= SQ_BOOT_WAIT;
        SQ_BOOT_WAIT: if (eng_done) begin
          if (bidx == BIW'(BOOT_LEN - 1)) begin
            sq       <= SQ_IDLE;
            dn_rst_n <= 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
            sq   <= SQ_BOOT_GO;
          end
        end
        SQ_IDLE: if (cmd_valid) sq <= SQ_BUSY;
        default: if (eng_done) sq <= SQ_IDLE;
      endcase
    end
  end

  assign scl_o = 1'b0;
  assign sda_o = 1'b0;
  assign scl_t = scl_hi;
  assign sda_t = sda_hi;

  // R8: the error flag never clears outside reset
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |=> ack_err);
  // R3: downstream release follows a finished engine transfer
  p_release_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_rst_n) |-> $past(eng_done));
  // R6: no command is accepted while the engine is still working
  p_accept_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> !eng_busy);

endmodule

// File: tb/vbc_top_bench.sv
module vbc_top_bench;
  localparam int QTR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_reg = '0, cmd_data = '0;
  logic       cmd_ready, cmd_done, ack_err, dn_rst_n;
  logic       scl_o, scl_t, sda_o, sda_t;
  logic       slv_pull = 1'b0;
  logic       scl_ln, sda_ln;

  always #2.5 clk = ~clk;

  assign scl_ln = scl_t ? 1'b1 : scl_o;
  assign sda_ln = (sda_t ? 1'b1 : sda_o) & ~slv_pull;

  vbc_top #(.DEV_ADDR(7'h76), .QTR_CYC(QTR)) u_vbc_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_reg(cmd_reg), .cmd_data(cmd_data), .cmd_done(cmd_done),
    .ack_err(ack_err), .dn_rst_n(dn_rst_n), .scl_o(scl_o), .scl_t(scl_t),
    .sda_o(sda_o), .sda_t(sda_t), .sda_i(sda_ln)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // slave model on the falling system clock edge
  int         nack_at = -1;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         bitc = 0, bytec = 0, hcnt = 0;
  int         hmin = 1000, hmax = 0;
  int         n_start = 0, n_stop = 0, log_n = 0;
  logic [7:0] shr = '0;
  logic [7:0] fb [0:2];
  logic [7:0] log_b [0:31][0:2];
  int         log_nb [0:31];

  always @(negedge clk) begin
    if (!rst_n) begin
      bitc = 0; bytec = 0; log_n = 0; n_start = 0; n_stop = 0;
      slv_pull = 1'b0; hcnt = 0;
    end else begin
      if (scl_ln) hcnt++;
      if (scl_ln && p_scl && p_sda && !sda_ln) begin
        n_start++; bitc = 0; bytec = 0; slv_pull = 1'b0;
      end else if (scl_ln && p_scl && !p_sda && sda_ln) begin
        n_stop++;
        if (log_n < 32) begin
          for (int k = 0; k < 3; k++) log_b[log_n][k] = fb[k];
          log_nb[log_n] = bytec;
          log_n++;
        end
      end else if (!p_scl && scl_ln) begin
        hcnt = 1;
        if (bitc < 8) shr = {shr[6:0], sda_ln};
        bitc++;
      end else if (p_scl && !scl_ln) begin
        if (bitc > 0) begin
          if (hcnt < hmin) hmin = hcnt;
          if (hcnt > hmax) hmax = hcnt;
        end
        if (bitc == 8) begin
          if (bytec < 3) fb[bytec] = shr;
          slv_pull = (bytec != nack_at);
        end else if (bitc == 9) begin
          slv_pull = 1'b0; bitc = 0; bytec++;
        end
      end
    end
    p_scl = scl_ln; p_sda = sda_ln;
  end

  localparam logic [15:0] BOOT_EXP [0:4] =
    '{16'h49C0, 16'h2109, 16'h3308, 16'h3416, 16'h3660};

  // {reg, data, refused byte index (FF = none)}
  localparam logic [23:0] VEC [0:5] = '{
    24'h1234FF, 24'h00FFFF, 24'hFF00FF, 24'hA55AFF, 24'h408102, 24'h077000};

  task automatic check_boot(input string tag, input int exp_nb);
    chk(log_n == 5, {tag, " boot frame count"}, log_n, 5);
    for (int i = 0; i < 5 && i < log_n; i++) begin
      chk(log_b[i][0] == 8'hEC, {tag, " R2 address byte"}, log_b[i][0], 8'hEC);
      chk(log_b[i][1] == BOOT_EXP[i][15:8], {tag, " R2 register"}, log_b[i][1], BOOT_EXP[i][15:8]);
      chk(log_b[i][2] == BOOT_EXP[i][7:0], {tag, " R2 value"}, log_b[i][2], BOOT_EXP[i][7:0]);
      chk(log_nb[i] == exp_nb, {tag, " R4 byte count"}, log_nb[i], exp_nb);
    end
  endtask

  task automatic wait_done();
    while (cmd_done !== 1'b1) @(negedge clk);
    @(negedge clk);
    chk(cmd_done == 1'b0, "R6 done pulse one cycle", cmd_done, 0);
  endtask

  task automatic issue(input logic [7:0] r, input logic [7:0] d);
    while (cmd_ready !== 1'b1) @(negedge clk);
    cmd_reg = r; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_err;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(scl_t == 1 && sda_t == 1, "R1 lines released in reset", {scl_t, sda_t}, 3);
    chk(scl_o == 0 && sda_o == 0, "R1 output values low", {scl_o, sda_o}, 0);
    chk(dn_rst_n == 0 && cmd_ready == 0 && ack_err == 0, "R1 status in reset",
        {dn_rst_n, cmd_ready, ack_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dn_rst_n == 0 && cmd_ready == 0, "R1 held after reset", {dn_rst_n, cmd_ready}, 0);

    // R2 R3 boot list
    while (dn_rst_n !== 1'b1) begin
      chk(cmd_ready == 0, "R3 ready low in boot", cmd_ready, 0);
      @(negedge clk);
    end
    chk(log_n == 5, "R3 release after fifth STOP", log_n, 5);
    check_boot("boot", 3);
    chk(cmd_ready == 1, "R3 ready after boot", cmd_ready, 1);
    chk(ack_err == 0, "R8 no error on clean boot", ack_err, 0);

    // table of commands
    exp_err = 0;
    for (int v = 0; v < 6; v++) begin
      int base, nb;
      nack_at = (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]);
      nb = (nack_at < 0) ? 3 : nack_at + 1;
      base = log_n;
      issue(VEC[v][23:16], VEC[v][15:8]);
      cmd_data = ~VEC[v][15:8];  // R7: late change must not leak
      cmd_reg  = ~VEC[v][23:16];
      chk(cmd_ready == 0, "R6 ready low while busy", cmd_ready, 0);
      wait_done();
      if (nack_at >= 0) exp_err = 1;
      chk(log_n == base + 1, "R6 one frame per command", log_n, base + 1);
      chk(log_nb[base] == nb, "R8 R4 bytes before STOP", log_nb[base], nb);
      chk(log_b[base][0] == 8'hEC, "R4 address byte", log_b[base][0], 8'hEC);
      if (nb == 3) begin
        chk(log_b[base][1] == VEC[v][23:16], "R7 register captured", log_b[base][1], VEC[v][23:16]);
        chk(log_b[base][2] == VEC[v][15:8], "R7 data captured", log_b[base][2], VEC[v][15:8]);
      end
      chk(ack_err == exp_err, "R8 sticky error flag", ack_err, exp_err);
    end
    nack_at = -1;

    // R7: second command held while the first runs
    begin
      int base;
      base = log_n;
      issue(8'h5C, 8'hC5);
      cmd_reg = 8'h6D; cmd_data = 8'hD6; cmd_valid = 1'b1;
      repeat (20) @(negedge clk);
      chk(cmd_ready == 0 && log_n == base, "R7 held command waits", log_n, base);
      while (cmd_done !== 1'b1) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      chk(log_n == base + 2, "R7 both frames sent", log_n, base + 2);
      chk(log_b[base][1] == 8'h5C && log_b[base][2] == 8'hC5, "R7 first frame",
          {log_b[base][1], log_b[base][2]}, 16'h5CC5);
      chk(log_b[base+1][1] == 8'h6D && log_b[base+1][2] == 8'hD6, "R7 held frame",
          {log_b[base+1][1], log_b[base+1][2]}, 16'h6DD6);
    end

    // R5 R9 line discipline so far
    chk(n_start == log_n && n_stop == log_n, "R5 one START and STOP per frame", n_start, log_n);
    chk(hmin == 2 * QTR && hmax == 2 * QTR, "R9 clock high width", hmax, 2 * QTR);

    // R8: refused data byte on every boot write
    nack_at = 2;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(ack_err == 0, "R1 error cleared by reset", ack_err, 0);
    rst_n = 1'b1;
    while (dn_rst_n !== 1'b1) @(negedge clk);
    check_boot("nack boot R8", 3);
    chk(ack_err == 1, "R8 error after boot refusal", ack_err, 1);
    chk(cmd_ready == 1, "R8 boot continues to ready", cmd_ready, 1);
    nack_at = -1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule